// File: doc/BRIEF.md
# Slow Clock Delay Tap Generator

This block follows a slow, asynchronous bus clock from inside a fast clock domain. It samples the slow clock into a shift chain that runs on the fast clock. The chain supplies delayed copies of the slow clock, so each tap step equals one fast clock period. Fast-domain logic uses these copies to decide when a slow bus access may begin and when fast operation may resume.

Two delayed level outputs are provided. The primary delayed clock is a selected tap combined by OR with the live slow clock, so it never stays low into the next high phase. The secondary delayed clock trails the primary by one fast period. A mode input selects a shorter primary tap, which gives enough setup time when the slow bus runs at the higher of its two rates. Read accesses and write accesses each have their own restart pulse, and each has its own tap selection. A combined restart output follows the current access direction.

Top module: `slowclk_tap_gen`

## Requirements
- R1: While rst_n is low, the chain is held clear: `phi_dly` and `phi_dly2` equal the live `slow_clk`, and no restart output is high.
- R2: With `fast_mode` = 0, `phi_dly` equals the `slow_clk` value sampled NORM_TAP+1 rising clock edges ago, OR-ed with the live `slow_clk` (default NORM_TAP = 14).
- R3: Whenever `slow_clk` is high, `phi_dly` and `phi_dly2` are high in the same cycle, without waiting for a clock edge.
- R4: `phi_dly2` equals the `slow_clk` value sampled one edge further back than the one `phi_dly` uses, OR-ed with the live `slow_clk`. Its falling edge therefore comes exactly one period after that of `phi_dly`.
- R5: With `fast_mode` = 1, `phi_dly` and `phi_dly2` use tap FAST_TAP (default 4) in place of NORM_TAP.
- R6: Let k be the value of `rd_sel`. `restart_rd` is high for exactly one cycle: the cycle in which the sample taken k+1 edges ago is 0 and the sample taken k+2 edges ago is 1.
- R7: `restart_wr` behaves as in R6, using `wr_sel` in place of `rd_sel`.
- R8: A select value below MIN_RESTART (default 1) is treated as MIN_RESTART. A restart pulse therefore never starts fewer than two sampling edges after `slow_clk` falls.
- R9: `restart` equals `restart_rd` when `access_read` = 1 (read) and equals `restart_wr` when `access_read` = 0 (write).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low reset, clears the chain |
| slow_clk | input | 1 | Asynchronous slow bus clock |
| fast_mode | input | 1 | 1 selects the short primary tap |
| rd_sel | input | SEL_W | Tap select for the read restart |
| wr_sel | input | SEL_W | Tap select for the write restart |
| access_read | input | 1 | Current access direction, 1 = read |
| phi_dly | output | 1 | Primary delayed slow clock, OR-ed with the live clock |
| phi_dly2 | output | 1 | Secondary delayed clock, one period later |
| restart_rd | output | 1 | One-cycle read restart pulse |
| restart_wr | output | 1 | One-cycle write restart pulse |
| restart | output | 1 | Restart pulse for the current direction |

## Verification
A single wrong chain stage shifts or damages every later tap. It appears as a `phi_dly` falling edge one period early or late, or as a restart pulse in the wrong cycle, one to thirty-three edges after a slow clock fall. The first low phase after such a fault shows it. A fault in the OR with the live clock or in the mode selection shows in the same cycle that `slow_clk` or `fast_mode` changes. The stimuli cover both slow clock rates, short slow clock pulses, the clamped select value, the largest select value, and switching the access direction.

// File: rtl/slowclk_tap_gen.sv
module slowclk_tap_gen #(
  parameter int SEL_W       = 5,
  parameter int NORM_TAP    = 14,
  parameter int FAST_TAP    = 4,
  parameter int MIN_RESTART = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_clk,
  input  logic             fast_mode,
  input  logic [SEL_W-1:0] rd_sel,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             access_read,
  output logic             phi_dly,
  output logic             phi_dly2,
  output logic             restart_rd,
  output logic             restart_wr,
  output logic             restart
);
  localparam int DEPTH = (1 << SEL_W) + 1;
  localparam logic [SEL_W:0] MIN_K = (SEL_W+1)'(MIN_RESTART);

  logic [DEPTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) chain <= '0;
    else        chain <= {chain[DEPTH-2:0], slow_clk};

  assign phi_dly  = slow_clk | (fast_mode ? chain[FAST_TAP]   : chain[NORM_TAP]);
  assign phi_dly2 = slow_clk | (fast_mode ? chain[FAST_TAP+1] : chain[NORM_TAP+1]);

  logic [1:0][SEL_W-1:0] sel;
  logic [1:0]            fire;
  assign sel = {wr_sel, rd_sel};

  for (genvar g = 0; g < 2; g++) begin : g_restart
    logic [SEL_W:0] k, k1;
    assign k    = ({1'b0, sel[g]} < MIN_K) ? MIN_K : {1'b0, sel[g]};
    assign k1   = k + 1'b1;
    assign fire[g] = ~chain[k] & chain[k1];
  end

  assign restart_rd = fire[0];
  assign restart_wr = fire[1];
  assign restart    = access_read ? restart_rd : restart_wr;

  a_r6_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    restart_rd |=> (!restart_rd || !$stable(rd_sel)));
  a_r7_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    restart_wr |=> (!restart_wr || !$stable(wr_sel)));
  a_r3_fall_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phi_dly) |-> !slow_clk);
  a_r4_dly2_fall_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phi_dly2) |-> !slow_clk);
  a_r9_dir_read: assert property (@(posedge clk) disable iff (!rst_n)
    (access_read && !restart_rd) |-> !restart);
endmodule

// File: tb/slowclk_tap_gen_test.sv
module slowclk_tap_gen_test;
  localparam int PERIOD = 20;
  localparam int NT = 14, FT = 4, MINR = 1;

  logic clk = 0, rst_n = 0, slow_clk = 0, fast_mode = 0, access_read = 1;
  logic [4:0] rd_sel = 5'd1, wr_sel = 5'd5;
  logic phi_dly, phi_dly2, restart_rd, restart_wr, restart;

  slowclk_tap_gen uut (.clk, .rst_n, .slow_clk, .fast_mode, .rd_sel, .wr_sel,
    .access_read, .phi_dly, .phi_dly2, .restart_rd, .restart_wr, .restart);

  always #(PERIOD/2) clk = ~clk;

  typedef struct packed { logic p1, p2, rr, rw, rs; } exp_t;
  exp_t q[$];
  logic h[0:40];
  int checks = 0, fails = 0;

  function automatic int clampk(input logic [4:0] s);
    return (s < MINR) ? MINR : int'(s);
  endfunction

  task automatic step(input logic s, input logic fm, input logic [4:0] rs,
                      input logic [4:0] ws, input logic ar);
    exp_t e;
    int p, kr, kw;
    @(posedge clk); #2;
    slow_clk = s; fast_mode = fm; rd_sel = rs; wr_sel = ws; access_read = ar;
    for (int i = 40; i > 0; i--) h[i] = h[i-1];
    h[0] = s;
    p = fm ? FT : NT;
    kr = clampk(rs); kw = clampk(ws);
    e.p1 = h[p+1] | h[0];
    e.p2 = h[p+2] | h[0];
    e.rr = !h[kr+1] & h[kr+2];
    e.rw = !h[kw+1] & h[kw+2];
    e.rs = ar ? e.rr : e.rw;
    q.push_back(e);
  endtask

  task automatic slow_wave(input int hi, input int lo, input int n, input logic fm,
                           input logic [4:0] rs, input logic [4:0] ws, input logic ar);
    for (int c = 0; c < n; c++) begin
      for (int i = 0; i < hi; i++) step(1'b1, fm, rs, ws, ar);
      for (int i = 0; i < lo; i++) step(1'b0, fm, rs, ws, ar);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (phi_dly !== e.p1) begin fails++; $display("FAIL R2/R3/R5 phi_dly got %b exp %b", phi_dly, e.p1); end
        if (phi_dly2 !== e.p2) begin fails++; $display("FAIL R4 phi_dly2 got %b exp %b", phi_dly2, e.p2); end
        if (restart_rd !== e.rr) begin fails++; $display("FAIL R6/R8 restart_rd got %b exp %b", restart_rd, e.rr); end
        if (restart_wr !== e.rw) begin fails++; $display("FAIL R7 restart_wr got %b exp %b", restart_wr, e.rw); end
        if (restart !== e.rs) begin fails++; $display("FAIL R9 restart got %b exp %b", restart, e.rs); end
      end
    end
  end

  initial begin : watchdog
    #(PERIOD*200000);
    fails++;
    $display("FAIL watchdog expired got hang exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i <= 40; i++) h[i] = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state follows the live clock only
    slow_clk = 1; #1;
    checks++;
    if (phi_dly !== 1'b1 || phi_dly2 !== 1'b1 || restart !== 1'b0) begin
      fails++; $display("FAIL R1 reset high got %b%b%b exp 110", phi_dly, phi_dly2, restart);
    end
    slow_clk = 0; #1;
    checks++;
    if (phi_dly !== 1'b0 || restart_rd !== 1'b0 || restart_wr !== 1'b0) begin
      fails++; $display("FAIL R1 reset low got %b%b%b exp 000", phi_dly, restart_rd, restart_wr);
    end
    @(posedge clk); #2; rst_n = 1;
    // R2 R6 R7: slow rate, normal mode, read
    slow_wave(25, 25, 3, 1'b0, 5'd1, 5'd5, 1'b1);
    // R9: write direction
    slow_wave(25, 25, 2, 1'b0, 5'd3, 5'd2, 1'b0);
    // R5: fast rate with fast mode
    slow_wave(12, 13, 4, 1'b1, 5'd1, 5'd1, 1'b1);
    // R3: normal mode at fast rate, tap runs into next high phase
    slow_wave(12, 13, 3, 1'b0, 5'd2, 5'd4, 1'b0);
    // R8: clamped select value 0
    slow_wave(20, 20, 2, 1'b0, 5'd0, 5'd0, 1'b1);
    // R6 R7: largest select value
    slow_wave(25, 40, 2, 1'b1, 5'd31, 5'd30, 1'b0);
    // short pulses, direction toggling
    for (int c = 0; c < 30; c++) step(c[1] ^ c[3], c[2], 5'(c), 5'(31 - c), c[0]);
    slow_wave(1, 3, 10, 1'b0, 5'd2, 5'd1, 1'b1);
    slow_wave(0, 45, 1, 1'b0, 5'd2, 5'd1, 1'b1);
    @(negedge clk); @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule